// File: doc/BRIEF.md
# Instruction Address Counter

This block keeps the address of the instruction that is running in a processor where each instruction takes several clock cycles. The control unit gives it a 2-bit step code in every cycle. With that code the counter keeps its value, moves forward by one, moves by a signed displacement taken from the held instruction word, or loads a target address that is read from a register port. The control unit resolves any branch condition before the code reaches this block.

The current address goes straight to the memory address multiplexer. The counter has to stay stable while one instruction is fetched and executed, so the control unit holds it in every cycle except the one in which the instruction is done.

Top module: `pcUnit`

## Requirements
- R1: While rstN is low, pcOut is 0 after the next rising clock edge. After rstN is released, a hold step gives pcOut 0.
- R2: Step code 2'b00 (hold) leaves pcOut unchanged after the edge.
- R3: Step code 2'b01 (increment) sets pcOut to the old value plus 1.
- R4: Step code 2'b10 (relative) adds a 6-bit signed displacement to pcOut. The displacement is {instr[8:6], instr[2:0]} with bit 8 as its sign, and it is sign-extended to 16 bits before the add.
- R5: Step code 2'b11 (absolute) loads pcOut from regA.
- R6: All sums wrap modulo 2^16. An increment from 16'hFFFF gives 0, and a relative step with displacement -1 from 0 gives 16'hFFFF.
- R7: Instruction bits outside [8:6] and [2:0] have no effect on a relative step. regA has no effect unless the step code is 2'b11.
- R8: pcOut changes only on a rising clock edge. Every update is registered, with a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepCode | input | 2 | Step selection: 00 hold, 01 increment, 10 relative, 11 absolute |
| instr | input | 16 | Held instruction word, the source of the displacement |
| regA | input | 16 | Register A-port value, the target for an absolute step |
| pcOut | output | 16 | Current instruction address |

## Verification
The bench runs each step code on its own and in runs of the same code. Long holds show that the value is retained, and chains of increments show that the counter carries. Relative steps use both positive and negative displacements, with noise on the unused instruction bits, so a wrong field split or a missing sign extension shows up at once. Absolute steps use random register values while regA changes during other steps, which shows that the target only loads under code 11. Steps at 16'hFFFF and at 0 check that the sums wrap.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int PC_W  = 16;
  localparam int OFS_W = 6;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_INC  = 2'b01,
    STEP_REL  = 2'b10,
    STEP_ABS  = 2'b11
  } stepT;

  typedef struct packed {
    logic load;
    logic useSum;
    logic useOfs;
  } pcCtlT;
endpackage

// File: rtl/pcCtl.sv
module pcCtl
  import pc_pkg::*;
(
  input  logic [1:0] stepCode,
  output pcCtlT      ctl
);
  always_comb begin
    ctl = '0;
    unique case (stepT'(stepCode))
      STEP_HOLD: ctl = '0;
      STEP_INC:  begin ctl.load = 1'b1; ctl.useSum = 1'b1; end
      STEP_REL:  begin ctl.load = 1'b1; ctl.useSum = 1'b1; ctl.useOfs = 1'b1; end
      STEP_ABS:  ctl.load = 1'b1;
      default:   ctl = '0;
    endcase
  end
endmodule

// File: rtl/pcPath.sv
module pcPath
  import pc_pkg::*;
#(
  parameter int W = PC_W,
  parameter int OW = OFS_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  pcCtlT        ctl,
  input  logic [W-1:0] instr,
  input  logic [W-1:0] regA,
  output logic [W-1:0] pcQ
);
  localparam int HALF = OW / 2;

  logic [OW-1:0] ofsField;
  logic [W-1:0]  ofsExt;
  logic [W-1:0]  addend;
  logic [W-1:0]  sumVal;
  logic [W-1:0]  nextVal;

  assign ofsField = {instr[3*HALF-1:2*HALF], instr[HALF-1:0]};
  assign ofsExt   = {{(W-OW){ofsField[OW-1]}}, ofsField};
  assign addend   = ctl.useOfs ? ofsExt : W'(1);
  assign sumVal   = pcQ + addend;
  assign nextVal  = ctl.useSum ? sumVal : regA;

  always_ff @(posedge clk) begin
    if (!rstN)         pcQ <= '0;
    else if (ctl.load) pcQ <= nextVal;
  end
endmodule

// File: rtl/pcUnit.sv
module pcUnit
  import pc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  stepCode,
  input  logic [15:0] instr,
  input  logic [15:0] regA,
  output logic [15:0] pcOut
);
  pcCtlT ctl;

  pcCtl u_ctl (.stepCode(stepCode), .ctl(ctl));

  pcPath #(.W(PC_W), .OW(OFS_W)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .instr(instr), .regA(regA), .pcQ(pcOut)
  );
endmodule

// File: rtl/pcUnit_chk.sv
module pcUnit_chk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  stepCode,
  input logic [15:0] instr,
  input logic [15:0] regA,
  input logic [15:0] pcOut
);
  logic live;
  always_ff @(posedge clk) live <= rstN;

  AST_RESET_ZERO: assert property (@(posedge clk) !rstN |=> pcOut == 16'h0); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (live && stepCode == 2'b00) |=> $stable(pcOut)); // R2
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (live && stepCode == 2'b01) |=> pcOut == 16'($past(pcOut) + 16'd1)); // R3
  AST_REL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (live && stepCode == 2'b10) |=> pcOut == 16'($past(pcOut) +
      {{10{$past(instr[8])}}, $past(instr[8:6]), $past(instr[2:0])})); // R4
  AST_ABS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (live && stepCode == 2'b11) |=> pcOut == $past(regA)); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (live && stepCode == 2'b01 && pcOut == 16'hFFFF) |=> pcOut == 16'h0); // R6
endmodule

bind pcUnit pcUnit_chk u_chk (.*);

// File: tb/pcUnit_tb.sv
module pcUnit_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic [1:0]  stepCode = 0;
  logic [15:0] instr = 0;
  logic [15:0] regA = 0;
  logic [15:0] pcOut;
  int nChk = 0, nBad = 0;
  int unsigned model = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pcUnit u_dut (.*);

  task automatic check(string req);
    nChk++;
    if (pcOut !== 16'(model)) begin
      nBad++;
      $display("FAIL %s: pcOut=%h expected=%h", req, pcOut, 16'(model));
    end
  endtask

  task automatic step(input logic [1:0] c, input logic [15:0] ins,
                      input logic [15:0] ra, input string req);
    int ofs;
    stepCode = c; instr = ins; regA = ra;
    @(posedge clk);
    ofs = {ins[8:6], ins[2:0]};
    if (ofs >= 32) ofs -= 64;
    case (c)
      2'b00: ;
      2'b01: model = (model + 1) & 16'hFFFF;
      2'b10: model = (model + 65536 + ofs) & 16'hFFFF;
      2'b11: model = ra;
    endcase
    #2;
    check(req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: pcOut=%h expected=done", pcOut);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    regA = 16'h1234; stepCode = 2'b11;
    repeat (2) @(posedge clk);
    #2; model = 0; check("R1");
    rstN = 1;
    step(2'b00, 16'hFFFF, 16'hAAAA, "R1");
    for (int i = 0; i < 5; i++) step(2'b01, 16'h0, 16'h5555, "R3");
    for (int i = 0; i < 4; i++) step(2'b00, 16'hFFFF, 16'($urandom), "R2 R7");
    step(2'b10, 16'b0000_0000_1100_0011, 16'hFFFF, "R4");
    step(2'b10, 16'b0000_0001_1100_0000, 16'h0, "R4");
    step(2'b10, 16'hFE38, 16'h0, "R7");
    step(2'b11, 16'h0, 16'hFFFF, "R5");
    step(2'b01, 16'h0, 16'h0, "R6");
    step(2'b10, 16'h01C7, 16'h0, "R6");
    step(2'b10, 16'h0001, 16'h0, "R6");
    step(2'b11, 16'h0, 16'h7FFE, "R5");
    step(2'b10, 16'h00C3, 16'h0, "R4");
    for (int i = 0; i < 200; i++)
      step(2'($urandom), 16'($urandom), 16'($urandom), "R2 R3 R4 R5 R8");
    stepCode = 2'b01;
    #1; regA = 16'h4321; #1;
    nChk++;
    if (pcOut !== 16'(model)) begin
      nBad++;
      $display("FAIL R8: pcOut=%h expected=%h", pcOut, 16'(model));
    end
    step(2'b00, 16'h0, 16'h0, "R8");
    rstN = 0; @(posedge clk); #2; model = 0; check("R1");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule